// File: doc/BRIEF.md
# Addressed serial configuration port

This block is a three-wire configuration port. A host shifts a fixed-length frame in one bit at a time on the serial clock, most significant bit first. It then raises the latch enable. The trailing bits of the frame are an address. On the latch edge, the rest of the frame (the payload) is copied into the addressed register of a small bank. The bank contents leave the block as one flat parallel bus, and the datapath logic of the chip reads its settings from that bus.

A serial output presents the oldest bit in the shift register. It updates on the falling edge of the serial clock, so a device placed after this one in a chain samples a stable bit on the next rising edge. One long stream can therefore load several devices before a single shared latch pulse. An input turns the serial output off. While it is off, the output stays low.

Top module: `serial_cfg_port`

## Requirements
- R1: While `rst_n` is low, every bank register reads zero on `cfg_bus` and `sdo` is low.
- R2: On each rising edge of `sclk` the shift register moves one place toward its MSB and takes `sdata` into bit 0, so the first bit of a frame ends up in frame bit 20.
- R3: Frame bits [1:0] (the last two bits shifted in, with the earlier of the two as the high address bit) select the register. Frame bits [20:2] form the 19-bit payload, and the first bit shifted is the payload MSB.
- R4: A rising edge of `latch_en` writes the payload into register `addr`, which appears at `cfg_bus[addr*19 +: 19]`. The other registers keep their values.
- R5: The bank changes only at a rising edge of `latch_en`. Frames shifted while `latch_en` is low, and clock edges while `latch_en` stays high, leave `cfg_bus` unchanged.
- R6: When more than 21 bits are shifted before a latch, only the last 21 bits are used.
- R7: With `dout_en` high, `sdo` updates on each falling edge of `sclk` to frame bit 20, which is the bit shifted in 21 rising edges earlier.
- R8: With `dout_en` low, `sdo` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| sclk | input | 1 | Serial clock; data sampled on rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| sdata | input | 1 | Serial data in, MSB first |
| latch_en | input | 1 | Rising edge commits the payload to the addressed register |
| dout_en | input | 1 | Enables the chained serial output |
| sdo | output | 1 | Chained serial output, falling-edge timed |
| cfg_bus | output | 76 | Bank contents, register r at bits [r*19 +: 19] |

## Verification
The in-line assertions check on every rising clock edge that the shift register moves one place and takes the new bit, that the bank holds steady unless the latch has just risen, that a latch writes the pending payload into the addressed slot, and that the enabled output matches the oldest shifted bit. Some behaviour only shows in the bench scenarios. These are the exact field split of a frame into address and payload across all four slots, overwrites of a slot, over-length frames, a latch held high over many clocks, the reset values, and the output forced low when it is disabled.

// File: rtl/cfgport_pkg.sv
package cfgport_pkg;
   localparam int unsigned DEF_FRAME_W  = 21;
   localparam int unsigned DEF_ADDR_W   = 2;
   localparam int unsigned DEF_NUM_REGS = 4;

   // Bits needed to index NUM_REGS slots (at least one).
   function automatic int unsigned idx_bits(input int unsigned n);
      int unsigned b;
      b = 1;
      while ((1 << b) < n) b++;
      return b;
   endfunction
endpackage

// File: rtl/cfgport_shift.sv
module cfgport_shift #(
   parameter int unsigned FRAME_W = cfgport_pkg::DEF_FRAME_W
) (
   input  logic               sclk,
   input  logic               rst_n,
   input  logic               sdata,
   output logic [FRAME_W-1:0] frame_q
);
   generate
      if (FRAME_W < 2) begin : g_bad_width
         $error("cfgport_shift: FRAME_W must be at least 2");
      end
   endgenerate

   always_ff @(posedge sclk or negedge rst_n) begin
      if (!rst_n) frame_q <= '0;
      else        frame_q <= {frame_q[FRAME_W-2:0], sdata};
   end

   AST_SHIFT_NEW_BIT: assert property (@(posedge sclk) disable iff (!rst_n)
      1'b1 |=> frame_q[0] == $past(sdata));                       // R2
   AST_SHIFT_MOVES: assert property (@(posedge sclk) disable iff (!rst_n)
      1'b1 |=> frame_q[FRAME_W-1:1] == $past(frame_q[FRAME_W-2:0])); // R6
endmodule

// File: rtl/cfgport_bank.sv
module cfgport_bank #(
   parameter int unsigned ADDR_W    = cfgport_pkg::DEF_ADDR_W,
   parameter int unsigned NUM_REGS  = cfgport_pkg::DEF_NUM_REGS,
   parameter int unsigned PAYLOAD_W = cfgport_pkg::DEF_FRAME_W - cfgport_pkg::DEF_ADDR_W
) (
   input  logic                          sclk,
   input  logic                          rst_n,
   input  logic                          latch_en,
   input  logic [ADDR_W-1:0]             addr,
   input  logic [PAYLOAD_W-1:0]          payload,
   output logic [NUM_REGS*PAYLOAD_W-1:0] bank_q
);
   generate
      if (NUM_REGS < 1 || NUM_REGS > (1 << ADDR_W)) begin : g_bad_depth
         $error("cfgport_bank: NUM_REGS must be 1 .. 2**ADDR_W");
      end
      for (genvar r = 0; r < NUM_REGS; r++) begin : g_slot
         logic hit;
         assign hit = (addr == ADDR_W'(r));
         always_ff @(posedge latch_en or negedge rst_n) begin
            if (!rst_n)   bank_q[r*PAYLOAD_W +: PAYLOAD_W] <= '0;
            else if (hit) bank_q[r*PAYLOAD_W +: PAYLOAD_W] <= payload;
         end
      end
   endgenerate

   AST_BANK_HOLD: assert property (@(posedge sclk) disable iff (!rst_n)
      !$rose(latch_en) |-> $stable(bank_q));                       // R5
   AST_BANK_WRITE: assert property (@(posedge sclk) disable iff (!rst_n)
      ($rose(latch_en) && (int'(addr) < NUM_REGS)) |->
      bank_q[int'(addr)*PAYLOAD_W +: PAYLOAD_W] == payload);       // R4
endmodule

// File: rtl/cfgport_chain.sv
module cfgport_chain #(
   parameter bit HAS_DOUT = 1'b1
) (
   input  logic sclk,
   input  logic rst_n,
   input  logic dout_en,
   input  logic oldest_bit,
   output logic sdo
);
   generate
      if (HAS_DOUT) begin : g_dout
         logic sdo_q;
         always_ff @(negedge sclk or negedge rst_n) begin
            if (!rst_n) sdo_q <= 1'b0;
            else        sdo_q <= dout_en & oldest_bit;
         end
         assign sdo = dout_en & sdo_q;

         AST_CHAIN_BIT: assert property (@(posedge sclk) disable iff (!rst_n)
            dout_en |-> sdo == oldest_bit);                        // R7
      end else begin : g_no_dout
         assign sdo = 1'b0;
      end
   endgenerate
endmodule

// File: rtl/serial_cfg_port.sv
module serial_cfg_port #(
   parameter int unsigned FRAME_W  = cfgport_pkg::DEF_FRAME_W,
   parameter int unsigned ADDR_W   = cfgport_pkg::DEF_ADDR_W,
   parameter int unsigned NUM_REGS = cfgport_pkg::DEF_NUM_REGS,
   parameter bit          HAS_DOUT = 1'b1,
   localparam int unsigned PAYLOAD_W = FRAME_W - ADDR_W
) (
   input  logic                          sclk,
   input  logic                          rst_n,
   input  logic                          sdata,
   input  logic                          latch_en,
   input  logic                          dout_en,
   output logic                          sdo,
   output logic [NUM_REGS*PAYLOAD_W-1:0] cfg_bus
);
   generate
      if (ADDR_W < 1 || ADDR_W >= FRAME_W) begin : g_bad_split
         $error("serial_cfg_port: ADDR_W must be 1 .. FRAME_W-1");
      end
   endgenerate

   logic [FRAME_W-1:0] frame_q;

   cfgport_shift #(.FRAME_W(FRAME_W)) u_shift (
      .sclk   (sclk),
      .rst_n  (rst_n),
      .sdata  (sdata),
      .frame_q(frame_q)
   );

   // Address trails the frame; payload leads it.
   cfgport_bank #(
      .ADDR_W   (ADDR_W),
      .NUM_REGS (NUM_REGS),
      .PAYLOAD_W(PAYLOAD_W)
   ) u_bank (
      .sclk    (sclk),
      .rst_n   (rst_n),
      .latch_en(latch_en),
      .addr    (frame_q[ADDR_W-1:0]),
      .payload (frame_q[FRAME_W-1:ADDR_W]),
      .bank_q  (cfg_bus)
   );

   cfgport_chain #(.HAS_DOUT(HAS_DOUT)) u_chain (
      .sclk      (sclk),
      .rst_n     (rst_n),
      .dout_en   (dout_en),
      .oldest_bit(frame_q[FRAME_W-1]),
      .sdo       (sdo)
   );
endmodule

// File: tb/sim_serial_cfg_port.sv
`timescale 1ns/1ps
module sim_serial_cfg_port;
   localparam int FW = 21;
   localparam int PW = 19;
   localparam int NR = 4;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic sdata = 1'b0;
   logic latch_en = 1'b0;
   logic dout_en = 1'b0;
   logic sdo;
   logic [NR*PW-1:0] cfg_bus;

   int n_checks = 0;
   int n_fail = 0;

   logic [PW-1:0] exp_regs [NR];
   logic [FW-1:0] model;  // expected shift contents per R2

   always #2.5 clk = ~clk;

   serial_cfg_port u0 (
      .sclk(clk), .rst_n(rst_n), .sdata(sdata), .latch_en(latch_en),
      .dout_en(dout_en), .sdo(sdo), .cfg_bus(cfg_bus)
   );

   always @(posedge clk or negedge rst_n)
      if (!rst_n) model <= '0;
      else        model <= {model[FW-2:0], sdata};

   localparam logic [FW-1:0] VEC [6] = '{
      {19'h5A5A5, 2'd0}, {19'h7FFFF, 2'd1}, {19'h00001, 2'd2},
      {19'h40000, 2'd3}, {19'h12345, 2'd1}, {19'h00000, 2'd0}
   };

   function automatic logic [NR*PW-1:0] exp_bus();
      logic [NR*PW-1:0] b;
      for (int r = 0; r < NR; r++) b[r*PW +: PW] = exp_regs[r];
      return b;
   endfunction

   task automatic chk(input bit ok, input string req,
                      input logic [127:0] act, input logic [127:0] exp);
      n_checks++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
      end
   endtask

   task automatic shift_bits(input logic [31:0] bits, input int n);
      for (int i = n - 1; i >= 0; i--) begin
         @(negedge clk);
         sdata = bits[i];
      end
      @(negedge clk);  // last bit captured on the rising edge before this
   endtask

   task automatic pulse_latch();
      latch_en = 1'b1;
      #1;
      @(negedge clk);
      latch_en = 1'b0;
   endtask

   task automatic check_bus(input string req);
      chk(cfg_bus == exp_bus(), req, 128'(cfg_bus), 128'(exp_bus()));
   endtask

   initial begin
      #200000;
      n_checks++;
      n_fail++;
      $display("FAIL watchdog expired actual=hung expected=done");
      $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
      $finish;
   end

   initial begin
      for (int r = 0; r < NR; r++) exp_regs[r] = '0;
      #1;
      // R1: reset values
      chk(cfg_bus == '0, "R1 bank reset", 128'(cfg_bus), 128'(0));
      chk(sdo == 1'b0, "R1 sdo reset", 128'(sdo), 128'(0));
      repeat (3) @(negedge clk);
      rst_n = 1'b1;

      // R3/R4: table of frames, each latched into its slot
      foreach (VEC[k]) begin
         shift_bits(32'(VEC[k]), FW);
         pulse_latch();
         exp_regs[VEC[k][1:0]] = VEC[k][FW-1:2];
         check_bus("R3 R4 frame decode and write");
      end

      // R5: full frame without latch leaves bank unchanged
      shift_bits(32'({19'h0BEEF, 2'd2}), FW);
      repeat (3) @(negedge clk);
      check_bus("R5 no latch no change");

      // R5: latch held high over many clocks writes only once
      shift_bits(32'({19'h33333, 2'd3}), FW);
      latch_en = 1'b1;
      exp_regs[3] = 19'h33333;
      #1;
      check_bus("R4 write at latch rise");
      shift_bits(32'({19'h11111, 2'd3}), FW);
      check_bus("R5 latch held high no rewrite");
      latch_en = 1'b0;
      #1;
      check_bus("R5 latch fall no write");

      // R6: over-length stream, only last 21 bits used
      shift_bits(32'({4'hF, 19'h2AAAA, 2'd2}), FW + 4);
      pulse_latch();
      exp_regs[2] = 19'h2AAAA;
      check_bus("R6 over-length frame");

      // R7: daisy chain output follows bit shifted 21 edges earlier
      @(posedge clk); #1;
      dout_en = 1'b1;
      shift_bits(32'h001A5C3, FW);
      chk(sdo == 1'b0, "R7 first chained bit", 128'(sdo), 128'(0));
      for (int i = 20; i >= 0; i--) begin
         @(negedge clk);
         sdata = ~sdata;
         #1;
         chk(sdo == model[FW-1], "R7 chained bit", 128'(sdo), 128'(model[FW-1]));
         if (i == 0)
            chk(sdo == model[FW-1], "R7 chain sample", 128'(sdo), 128'(model[FW-1]));
      end

      // R8: disabled output stays low
      shift_bits(32'h1FFFFF, FW);
      @(posedge clk); #1;
      dout_en = 1'b0;
      #0.5;
      chk(sdo == 1'b0, "R8 disable immediate", 128'(sdo), 128'(0));
      for (int i = 0; i < 5; i++) begin
         @(negedge clk); #1;
         chk(sdo == 1'b0, "R8 sdo low while disabled", 128'(sdo), 128'(0));
      end

      // R1: reset again clears bank and output
      rst_n = 1'b0;
      #1;
      for (int r = 0; r < NR; r++) exp_regs[r] = '0;
      check_bus("R1 bank cleared by reset");
      chk(sdo == 1'b0, "R1 sdo low in reset", 128'(sdo), 128'(0));

      $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
      $finish;
   end
endmodule